// File: doc/BRIEF.md
# Reset Strap Boot Sequencer

This block decides how a processor core obtains its program after reset and runs that boot. While reset is held it samples a boot-source strap and a small group of interface-mode straps. It keeps those levels until reset comes back. When reset is released it takes one of two routes:

- **Host route.** It waits until an external host reports that the download is complete.
- **Autoboot route.** It reads a byte-wide external memory itself. It first reads a little-endian byte count, then copies that many bytes into internal program RAM.

Autoboot is available only when the latched interface mode is serial, because the memory bus shares pins with the parallel host port.

The block also produces the core clock enable. Before boot completes, the core runs at a divided rate. Once boot is done, the core runs on every cycle. After boot, the pin that carried the boot strap becomes an active-low message interrupt. The block supplies the drive-low enable for that pin.

Top module: `boot_strap_seq`

## Requirements
- R1: The boot strap and the interface-mode straps are captured on every clock while `rst` is high. From the first cycle after release, `latched_host_o` and `latched_comm_o` hold the values from the final reset cycle, whatever the pins do afterwards.
- R2: If the latched boot strap is 1, the block waits for the host. `mem_rd_o` and `ram_we_o` stay 0. `boot_done_o` rises two cycles after a cycle in which `host_load_done_i` is 1, counting only pulses from the second cycle after release onward.
- R3: The MSB of the interface-mode field selects the mode: 0 means serial and 1 means parallel. `mem_if_en_o` is 1 only for a serial mode. If the boot strap is low and the mode is parallel, the block follows the host route of R2.
- R4: In autoboot, reads run in the order external address 0, address 1, then addresses 2 onwards. Each address is held with `mem_rd_o` high for WAIT_CYC+1 cycles, and the data is captured on the last of those cycles. The first read starts in the first cycle after release. The byte at address 0 is the low byte of the count and the byte at address 1 is the high byte.
- R5: For each body byte read from external address a, `ram_we_o` pulses for one cycle with `ram_addr_o` = a-2 and `ram_wdata_o` equal to that byte. The pulse comes in the cycle after the read's last cycle.
- R6: The number of body bytes loaded is the 16-bit count saturated to RAM_DEPTH. A count of zero loads no bytes.
- R7: `boot_done_o` rises in the cycle after the final write pulse. With a zero count, it rises two cycles after the last header read cycle. It stays high until reset, and no read is active while it is high.
- R8: `core_clk_en_o` is high in the cycles numbered n ≡ PRE_DIV-1 (mod PRE_DIV), where cycle 0 is the reset cycle and cycle n comes n edges after release, until boot is done. After that it is high on every cycle.
- R9: `irq_drive_o` equals `boot_done_o` AND `msg_pending_i`, so it never pulls the pin low before boot is done.
- R10: During reset, `boot_done_o`, `mem_rd_o`, `ram_we_o`, `core_clk_en_o` and `irq_drive_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| strap_boot_i | input | 1 | Boot-source strap level (1 = host, 0 = autoboot) |
| strap_comm_i | input | 2 | Interface-mode strap levels; MSB 1 = parallel |
| host_load_done_i | input | 1 | Host reports that the download is complete |
| msg_pending_i | input | 1 | Core has an outgoing message |
| mem_data_i | input | 8 | External memory read data |
| mem_addr_o | output | EXT_AW | External memory address |
| mem_rd_o | output | 1 | External read active |
| mem_if_en_o | output | 1 | External memory pins are enabled (serial mode latched) |
| ram_we_o | output | 1 | Program RAM write strobe |
| ram_addr_o | output | log2(RAM_DEPTH) | Program RAM write address |
| ram_wdata_o | output | 8 | Program RAM write data |
| boot_done_o | output | 1 | Boot complete |
| core_clk_en_o | output | 1 | Core clock enable |
| irq_drive_o | output | 1 | Pull the shared strap/interrupt pin low |
| latched_host_o | output | 1 | Latched boot strap |
| latched_comm_o | output | 2 | Latched interface mode |

## Verification
The bench builds the block with EXT_AW=8, RAM_DEPTH=16, WAIT_CYC=2 and PRE_DIV=4. The small RAM lets a 300-byte header count hit the saturation limit after only 18 reads. A three-cycle read window lets the bench see each address held over several cycles. A reference timeline in the bench derives the read address, write strobe, done flag and clock enable from the cycle number. Five scenarios are compared every cycle against that timeline: a normal load, a zero count, a saturated count, a strapped host boot, and a parallel mode that overrides the autoboot strap.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int COMM_W = 2;

    typedef struct packed {
        logic              host_boot;
        logic [COMM_W-1:0] comm;
    } strap_t;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_HOST,
        LD_HDR0,
        LD_HDR1,
        LD_BODY,
        LD_DONE
    } ld_state_e;

    // Serial modes have the mode MSB clear.
    function automatic logic is_serial(input logic [COMM_W-1:0] comm);
        return !comm[COMM_W-1];
    endfunction

    function automatic logic [15:0] clamp_count(input logic [15:0] raw,
                                                input logic [16:0] lim);
        return ({1'b0, raw} > lim) ? lim[15:0] : raw;
    endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
    import boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_boot_i,
    input  logic [COMM_W-1:0] strap_comm_i,
    output strap_t            straps_o
);
    strap_t straps_q;

    // Track the pins throughout reset; freeze on release.
    always_ff @(posedge clk) begin
        if (rst) begin
            straps_q <= '{host_boot: strap_boot_i, comm: strap_comm_i};
        end
    end

    assign straps_o = straps_q;

    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(straps_q)); // R1

endmodule

// File: rtl/boot_clk_ctrl.sv
module boot_clk_ctrl #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic boot_done_i,
    output logic clk_en_o
);
    localparam int DW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(PRE_DIV - 1);

    logic [DW-1:0] cnt;

    generate
        if ((PRE_DIV & (PRE_DIV - 1)) == 0) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst) cnt <= '0;
                else     cnt <= cnt + 1'b1;
            end
        end else begin : g_mod
            always_ff @(posedge clk) begin
                if (rst)             cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                 cnt <= cnt + 1'b1;
            end
        end
    endgenerate

    assign clk_en_o = boot_done_i | (cnt == LAST);

    AST_SLOW_GAP: assert property (@(posedge clk) disable iff (rst)
        (PRE_DIV > 1 && clk_en_o && !boot_done_i) |=> (!clk_en_o || boot_done_i)); // R8

endmodule

// File: rtl/boot_loader_fsm.sv
module boot_loader_fsm
    import boot_pkg::*;
#(
    parameter int EXT_AW    = 16,
    parameter int RAM_DEPTH = 4096,
    parameter int WAIT_CYC  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  strap_t                       straps_i,
    input  logic                         host_load_done_i,
    input  logic [7:0]                   mem_data_i,
    output logic [EXT_AW-1:0]            mem_addr_o,
    output logic                         mem_rd_o,
    output logic                         ram_we_o,
    output logic [$clog2(RAM_DEPTH)-1:0] ram_addr_o,
    output logic [7:0]                   ram_wdata_o,
    output logic                         boot_done_o
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam int WW     = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
    localparam logic [WW-1:0] WLAST = WW'(WAIT_CYC);

    ld_state_e         state;
    logic [WW-1:0]     wcnt;
    logic [7:0]        cnt_lo;
    logic [15:0]       total;
    logic [15:0]       idx;
    logic              fin_q, done_q, we_q;
    logic [RAM_AW-1:0] waddr_q;
    logic [7:0]        wdata_q;
    logic              host_sel, cap;
    logic [15:0]       raw_cnt;

    assign host_sel = straps_i.host_boot | !is_serial(straps_i.comm);
    assign cap      = (wcnt == WLAST);
    assign raw_cnt  = {mem_data_i, cnt_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LD_IDLE;
            wcnt    <= '0;
            cnt_lo  <= '0;
            total   <= '0;
            idx     <= '0;
            fin_q   <= 1'b0;
            done_q  <= 1'b0;
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            we_q  <= 1'b0;
            fin_q <= 1'b0;
            if (fin_q) done_q <= 1'b1;
            unique case (state)
                LD_IDLE: begin
                    wcnt  <= '0;
                    state <= host_sel ? LD_HOST : LD_HDR0;
                end
                LD_HOST: begin
                    if (host_load_done_i) begin
                        fin_q <= 1'b1;
                        state <= LD_DONE;
                    end
                end
                LD_HDR0: begin
                    if (cap) begin
                        cnt_lo <= mem_data_i;
                        wcnt   <= '0;
                        state  <= LD_HDR1;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                LD_HDR1: begin
                    if (cap) begin
                        wcnt  <= '0;
                        idx   <= '0;
                        total <= clamp_count(raw_cnt, 17'(RAM_DEPTH));
                        if (raw_cnt == 16'd0) begin
                            fin_q <= 1'b1;
                            state <= LD_DONE;
                        end else begin
                            state <= LD_BODY;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                LD_BODY: begin
                    if (cap) begin
                        we_q    <= 1'b1;
                        waddr_q <= idx[RAM_AW-1:0];
                        wdata_q <= mem_data_i;
                        wcnt    <= '0;
                        idx     <= idx + 16'd1;
                        if (idx + 16'd1 == total) begin
                            fin_q <= 1'b1;
                            state <= LD_DONE;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= LD_DONE;
            endcase
        end
    end

    always_comb begin
        mem_rd_o   = 1'b0;
        mem_addr_o = '0;
        case (state)
            LD_HDR0: mem_rd_o = 1'b1;
            LD_HDR1: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = EXT_AW'(1);
            end
            LD_BODY: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = EXT_AW'(idx + 16'd2);
            end
            default: ;
        endcase
    end

    assign ram_we_o    = we_q;
    assign ram_addr_o  = waddr_q;
    assign ram_wdata_o = wdata_q;
    assign boot_done_o = done_q;

    AST_HOST_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        host_sel |-> (!mem_rd_o && !ram_we_o)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && wcnt != '0) |-> $stable(mem_addr_o)); // R4
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        ram_we_o |-> $past(mem_rd_o)); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        boot_done_o |=> boot_done_o); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        boot_done_o |-> !mem_rd_o); // R7

endmodule

// File: rtl/boot_strap_seq.sv
module boot_strap_seq
    import boot_pkg::*;
#(
    parameter int EXT_AW    = 16,
    parameter int RAM_DEPTH = 4096,
    parameter int WAIT_CYC  = 2,
    parameter int PRE_DIV   = 4,
    localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_boot_i,
    input  logic [COMM_W-1:0] strap_comm_i,
    input  logic              host_load_done_i,
    input  logic              msg_pending_i,
    input  logic [7:0]        mem_data_i,
    output logic [EXT_AW-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_if_en_o,
    output logic              ram_we_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [7:0]        ram_wdata_o,
    output logic              boot_done_o,
    output logic              core_clk_en_o,
    output logic              irq_drive_o,
    output logic              latched_host_o,
    output logic [COMM_W-1:0] latched_comm_o
);
    strap_t straps;
    logic   done;

    boot_strap_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .strap_boot_i (strap_boot_i),
        .strap_comm_i (strap_comm_i),
        .straps_o     (straps)
    );

    boot_loader_fsm #(
        .EXT_AW    (EXT_AW),
        .RAM_DEPTH (RAM_DEPTH),
        .WAIT_CYC  (WAIT_CYC)
    ) u_loader (
        .clk              (clk),
        .rst              (rst),
        .straps_i         (straps),
        .host_load_done_i (host_load_done_i),
        .mem_data_i       (mem_data_i),
        .mem_addr_o       (mem_addr_o),
        .mem_rd_o         (mem_rd_o),
        .ram_we_o         (ram_we_o),
        .ram_addr_o       (ram_addr_o),
        .ram_wdata_o      (ram_wdata_o),
        .boot_done_o      (done)
    );

    boot_clk_ctrl #(.PRE_DIV(PRE_DIV)) u_clk (
        .clk         (clk),
        .rst         (rst),
        .boot_done_i (done),
        .clk_en_o    (core_clk_en_o)
    );

    assign boot_done_o    = done;
    assign irq_drive_o    = done & msg_pending_i;
    assign mem_if_en_o    = is_serial(straps.comm);
    assign latched_host_o = straps.host_boot;
    assign latched_comm_o = straps.comm;

    AST_SERIAL_ONLY_RD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> mem_if_en_o); // R3

endmodule

// File: tb/boot_strap_seq_tb_top.sv
module boot_strap_seq_tb_top;
    localparam int EXT_AW = 8, RAM_DEPTH = 16, WAIT_CYC = 2, PRE_DIV = 4;
    localparam int P = WAIT_CYC + 1;

    logic clk = 1'b0, rst = 1'b1;
    logic strap_boot = 1'b0, host_done = 1'b0, pend = 1'b0;
    logic [1:0] strap_comm = 2'b00;
    logic [7:0] mem_data;
    logic [EXT_AW-1:0] mem_addr;
    logic mem_rd, mem_if_en, ram_we, boot_done, clk_en, irq, l_host;
    logic [3:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [1:0] l_comm;
    logic [7:0] img [0:255];

    int total = 0, bad = 0, cyc = 0, wd = 0;

    always #4 clk = ~clk;

    assign mem_data = mem_rd ? img[mem_addr] : 8'h00;

    boot_strap_seq #(.EXT_AW(EXT_AW), .RAM_DEPTH(RAM_DEPTH), .WAIT_CYC(WAIT_CYC),
                     .PRE_DIV(PRE_DIV)) dut_i (
        .clk(clk), .rst(rst), .strap_boot_i(strap_boot), .strap_comm_i(strap_comm),
        .host_load_done_i(host_done), .msg_pending_i(pend), .mem_data_i(mem_data),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_if_en_o(mem_if_en),
        .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
        .boot_done_o(boot_done), .core_clk_en_o(clk_en), .irq_drive_o(irq),
        .latched_host_o(l_host), .latched_comm_o(l_comm));

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
        wd <= wd + 1;
        if (wd > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d exp<=20000", wd);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cyc=%0d act=%0d exp=%0d", tag, cyc, act, exp);
        end
    endtask

    // host: 1 = host route expected; hd: cycle in which host_done pulses
    task automatic run(input bit sboot, input logic [1:0] scomm, input int count,
                       input int hd, input bit p, input int seed);
        bit host;
        int n, r_tot, done_at, last;
        host = sboot | scomm[1];
        n = (count > RAM_DEPTH) ? RAM_DEPTH : count;
        r_tot = 2 + n;
        done_at = host ? hd + 2 : 2 + r_tot * P;
        last = done_at + 10;
        for (int a = 0; a < 256; a++) img[a] = 8'(a * 13 + seed);
        img[0] = 8'(count);
        img[1] = 8'(count >> 8);
        @(negedge clk);
        rst = 1'b1; strap_boot = sboot; strap_comm = scomm; pend = p; host_done = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!boot_done && !mem_rd && !ram_we && !clk_en && !irq, "R10 reset outputs",
                {boot_done, mem_rd, ram_we, clk_en, irq}, 0);
        end
        rst = 1'b0;
        strap_boot = ~sboot; strap_comm = ~scomm;   // pins move after release
        for (int k = 0; k < last; k++) begin
            bit done_e, rd_e, we_e, en_e;
            int ra, wr;
            @(negedge clk);
            done_e = cyc >= done_at;
            rd_e = !host && cyc >= 1 && cyc <= r_tot * P;
            ra = (cyc - 1) / P;
            we_e = !host && cyc > 1 && ((cyc - 1) % P == 0) &&
                   ((cyc - 1) / P >= 3) && ((cyc - 1) / P <= r_tot);
            wr = (cyc - 1) / P - 1;
            en_e = done_e || (cyc % PRE_DIV == PRE_DIV - 1);
            chk(l_host == sboot, "R1 latched boot strap", int'(l_host), int'(sboot));
            chk(l_comm == scomm, "R1 latched mode", int'(l_comm), int'(scomm));
            chk(mem_if_en == !scomm[1], "R3 mem if enable", int'(mem_if_en), int'(!scomm[1]));
            chk(mem_rd == rd_e, host ? "R2 no reads host route" : "R4 read active",
                int'(mem_rd), int'(rd_e));
            if (rd_e)
                chk(int'(mem_addr) == ra, "R4 read address", int'(mem_addr), ra);
            chk(ram_we == we_e, n == 0 ? "R6 zero count writes" : "R5 write strobe",
                int'(ram_we), int'(we_e));
            if (we_e) begin
                chk(int'(ram_addr) == wr - 2, "R5 ram address", int'(ram_addr), wr - 2);
                chk(ram_wdata == img[wr], "R5 ram data", int'(ram_wdata), int'(img[wr]));
            end
            chk(boot_done == done_e, host ? "R2 host done timing" : "R7 done timing",
                int'(boot_done), int'(done_e));
            chk(clk_en == en_e, "R8 clock enable", int'(clk_en), int'(en_e));
            chk(irq == (done_e && p), "R9 irq drive", int'(irq), int'(done_e && p));
            host_done = (cyc == hd);
        end
        host_done = 1'b0;
    endtask

    initial begin
        run(1'b0, 2'b00, 5,   0, 1'b1, 3);   // R4 R5 R7 normal autoboot
        run(1'b0, 2'b01, 0,   0, 1'b1, 7);   // R6 zero count
        run(1'b0, 2'b00, 300, 0, 1'b0, 11);  // R6 saturated count, high byte used
        run(1'b1, 2'b00, 5,   9, 1'b1, 5);   // R2 host strap
        run(1'b0, 2'b10, 5,   12, 1'b1, 9);  // R3 parallel mode forces host route
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule